// File: doc/BRIEF.md
# LCD raster timing generator

This block produces the scan timing for a parallel RGB panel that takes one pixel per clock. It drives a horizontal sync, a vertical sync, a data enable and the column and row of the current active pixel. Each axis is a repeating sequence of five phases. A single-slot reference phase comes first. Sync follows, then back porch, then the active region, then front porch. The reference slot always lasts exactly one slot and has no register of its own. Software that starts from a panel's nominal front porch therefore programs that value minus one, so the line length stays the same.

Software loads the timing as four 32-bit words. Three of them hold the sync width, the back porch and the front porch. The fourth holds the active size. In every word the horizontal value occupies bits 15:0 and the vertical value occupies bits 31:16. An external divider supplies a pixel clock enable. The raster moves one slot on each clock where that enable is high and holds otherwise. The block captures the timing words at frame boundaries, so software may rewrite them at any time without tearing the picture.

The block has no stream interface. Timing outputs run freely, paced only by the pixel enable. There is no back-pressure: a consumer that cannot keep up must slow the enable. All pins are plain control and status signals.

Top module: `lcd_raster_timing`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, the outputs are: `hsync_o`=1, `vsync_o`=1, `de`=0, `pix_x`=0, `pix_y`=0, `frame_start`=0. The timing words are captured on that first clock and no slot is consumed.
- R2: A line has 1+S+B+A+F slots, where S, B, A and F are the horizontal sync, back porch, active and front porch values. The slots run in the order reference, sync, back porch, active, front porch. `hsync_o` is at its asserted level in the sync slots and only there. With no inversion the asserted level is 0.
- R3: The row counter advances once per completed line. A frame has 1+S+B+A+F lines built from the vertical values in the same phase order. `vsync_o` is at its asserted level for the whole of each vertical sync line.
- R4: `de` is 1 exactly when both axes are in their active phase. `pix_x` and `pix_y` count from 0 at the first active slot and the first active line. Both are 0 whenever `de` is 0.
- R5: In `tm_sync`, `tm_back` and `tm_front`, bits 15:0 hold the horizontal value and bits 31:16 hold the vertical value. In `tm_active`, bits 15:0 hold the width and bits 31:16 hold the height.
- R6: A phase programmed to zero length takes no slot. The sequence goes straight on to the next phase.
- R7: When `hsync_inv` is 1, the asserted level of `hsync_o` becomes 1. `vsync_inv` does the same for `vsync_o`. The inversion bits are applied at each output update.
- R8: The outputs change only on clocks where `pix_ce` was high at the edge, and they hold their values otherwise.
- R9: `frame_start` is a one-clock pulse. It follows the `pix_ce` edge that presents slot 0 of line 0.
- R10: An active width above `MAX_W` is treated as `MAX_W`, and an active height above `MAX_H` is treated as `MAX_H`.
- R11: Timing words written during a frame take effect only from slot 0 of the next frame.
- R12: The outputs after the n-th advancing edge (n starting at 1) describe raster slot n-1 of the frame sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_ce | input | 1 | Pixel clock enable from the external divider |
| hsync_inv | input | 1 | Invert the horizontal sync level |
| vsync_inv | input | 1 | Invert the vertical sync level |
| tm_sync | input | 32 | Sync widths (vertical in 31:16, horizontal in 15:0) |
| tm_back | input | 32 | Back porches (vertical in 31:16, horizontal in 15:0) |
| tm_front | input | 32 | Front porches, already reduced by the reference slot |
| tm_active | input | 32 | Active height in 31:16, active width in 15:0 |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de | output | 1 | Data enable, high in the active area |
| pix_x | output | $clog2(MAX_W) | Active column |
| pix_y | output | $clog2(MAX_H) | Active row |
| frame_start | output | 1 | One-clock pulse at the frame origin |

## Verification
A position counter that slips shows up as a misplaced `hsync_o` or `de` edge within one line, and the very next advancing edge after the fault already disagrees with the slot model. A wrong row counter or a bad frame-boundary config capture only shows at the next line or frame edge. There `vsync_o`, `pix_y` or the `frame_start` position deviate, so the sweeps run at least two frames per configuration, with a timing change made mid-frame. A stuck enable path is caught on the first held clock, because outputs move when they should have stayed.

// File: rtl/lrt_pkg.sv
`timescale 1ns/1ps
package lrt_pkg;

  localparam int FIELD_W = 16;
  localparam int WORD_W  = 2 * FIELD_W;

  typedef enum logic [2:0] {
    PH_REF   = 3'd0,
    PH_SYNC  = 3'd1,
    PH_BACK  = 3'd2,
    PH_ACT   = 3'd3,
    PH_FRONT = 3'd4
  } phase_e;

  typedef struct packed {
    logic [FIELD_W-1:0] sync_len;
    logic [FIELD_W-1:0] back_len;
    logic [FIELD_W-1:0] act_len;
    logic [FIELD_W-1:0] front_len;
  } axis_cfg_t;

endpackage

// File: rtl/lrt_shadow.sv
`timescale 1ns/1ps
// Frame-boundary copy of the packed timing words, split per axis and clamped.
module lrt_shadow #(
  parameter int MAX_W = 1366,
  parameter int MAX_H = 768
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [lrt_pkg::WORD_W-1:0] w_sync,
  input  logic [lrt_pkg::WORD_W-1:0] w_back,
  input  logic [lrt_pkg::WORD_W-1:0] w_front,
  input  logic [lrt_pkg::WORD_W-1:0] w_active,
  output lrt_pkg::axis_cfg_t        h_cfg,
  output lrt_pkg::axis_cfg_t        v_cfg
);
  import lrt_pkg::*;

  localparam int NUM_AX = 2;

  axis_cfg_t nxt [NUM_AX];
  axis_cfg_t cur [NUM_AX];

  for (genvar ax = 0; ax < NUM_AX; ax++) begin : g_axis
    localparam int LIM = (ax == 0) ? MAX_W : MAX_H;
    logic [FIELD_W-1:0] raw_act;
    assign raw_act               = w_active[ax*FIELD_W +: FIELD_W];
    assign nxt[ax].sync_len      = w_sync[ax*FIELD_W +: FIELD_W];
    assign nxt[ax].back_len      = w_back[ax*FIELD_W +: FIELD_W];
    assign nxt[ax].front_len     = w_front[ax*FIELD_W +: FIELD_W];
    assign nxt[ax].act_len       = (raw_act > FIELD_W'(LIM)) ? FIELD_W'(LIM) : raw_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_AX; i++) cur[i] <= '0;
    end else if (load) begin
      for (int i = 0; i < NUM_AX; i++) cur[i] <= nxt[i];
    end
  end

  assign h_cfg = cur[0];
  assign v_cfg = cur[1];

endmodule

// File: rtl/lrt_axis.sv
`timescale 1ns/1ps
// One raster axis: slot position counter and phase decode by boundary compare.
module lrt_axis #(
  parameter int MAX_ACT = 1366
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        step,
  input  lrt_pkg::axis_cfg_t          cfg,
  output lrt_pkg::phase_e             phase,
  output logic [$clog2(MAX_ACT)-1:0]  coord,
  output logic                        last
);
  import lrt_pkg::*;

  localparam int CW = $clog2(MAX_ACT);
  localparam int PW = FIELD_W + 3;

  logic [PW-1:0] pos_q;
  logic [PW-1:0] at_sync, at_back, at_act, at_front, span;

  // Phase start positions; a zero-length phase shares its start with the next.
  always_comb begin
    at_sync  = PW'(1);
    at_back  = at_sync  + PW'(cfg.sync_len);
    at_act   = at_back  + PW'(cfg.back_len);
    at_front = at_act   + PW'(cfg.act_len);
    span     = at_front + PW'(cfg.front_len);
  end

  assign last = (pos_q >= span - PW'(1));

  always_comb begin
    if (pos_q < at_sync)       phase = PH_REF;
    else if (pos_q < at_back)  phase = PH_SYNC;
    else if (pos_q < at_act)   phase = PH_BACK;
    else if (pos_q < at_front) phase = PH_ACT;
    else                       phase = PH_FRONT;
  end

  assign coord = (phase == PH_ACT) ? CW'(pos_q - at_act) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos_q <= '0;
    else if (step) pos_q <= last ? '0 : pos_q + PW'(1);
  end

endmodule

// File: rtl/lrt_outreg.sv
`timescale 1ns/1ps
// Registered panel-side outputs, updated once per advancing pixel slot.
module lrt_outreg #(
  parameter int XW = 11,
  parameter int YW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  lrt_pkg::phase_e h_ph,
  input  lrt_pkg::phase_e v_ph,
  input  logic [XW-1:0]   h_coord,
  input  logic [YW-1:0]   v_coord,
  input  logic            h_inv,
  input  logic            v_inv,
  output logic            hsync_o,
  output logic            vsync_o,
  output logic            de,
  output logic [XW-1:0]   pix_x,
  output logic [YW-1:0]   pix_y,
  output logic            frame_start
);
  import lrt_pkg::*;

  logic in_area;
  logic at_origin;

  assign in_area   = (h_ph == PH_ACT) && (v_ph == PH_ACT);
  assign at_origin = (h_ph == PH_REF) && (v_ph == PH_REF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync_o <= 1'b1;
      vsync_o <= 1'b1;
      de      <= 1'b0;
      pix_x   <= '0;
      pix_y   <= '0;
    end else if (adv) begin
      hsync_o <= (h_ph != PH_SYNC) ^ h_inv;
      vsync_o <= (v_ph != PH_SYNC) ^ v_inv;
      de      <= in_area;
      pix_x   <= in_area ? h_coord : '0;
      pix_y   <= in_area ? v_coord : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_start <= 1'b0;
    else        frame_start <= adv && at_origin;
  end

endmodule

// File: rtl/lcd_raster_timing.sv
`timescale 1ns/1ps
module lcd_raster_timing #(
  parameter int MAX_W = 1366,
  parameter int MAX_H = 768
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pix_ce,
  input  logic                       hsync_inv,
  input  logic                       vsync_inv,
  input  logic [31:0]                tm_sync,
  input  logic [31:0]                tm_back,
  input  logic [31:0]                tm_front,
  input  logic [31:0]                tm_active,
  output logic                       hsync_o,
  output logic                       vsync_o,
  output logic                       de,
  output logic [$clog2(MAX_W)-1:0]   pix_x,
  output logic [$clog2(MAX_H)-1:0]   pix_y,
  output logic                       frame_start
);
  import lrt_pkg::*;

  localparam int XW = $clog2(MAX_W);
  localparam int YW = $clog2(MAX_H);

  logic      primed_q;
  logic      adv;
  logic      load;
  logic      h_last, v_last;
  phase_e    h_ph, v_ph;
  logic [XW-1:0] h_coord;
  logic [YW-1:0] v_coord;
  axis_cfg_t h_cfg, v_cfg;

  // First clock after reset captures the timing words; no slot is consumed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed_q <= 1'b0;
    else        primed_q <= 1'b1;
  end

  assign adv  = pix_ce && primed_q;
  assign load = !primed_q || (adv && h_last && v_last);

  lrt_shadow #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(load),
    .w_sync(tm_sync), .w_back(tm_back), .w_front(tm_front), .w_active(tm_active),
    .h_cfg(h_cfg), .v_cfg(v_cfg)
  );

  lrt_axis #(.MAX_ACT(MAX_W)) u_h_axis (
    .clk(clk), .rst_n(rst_n), .step(adv), .cfg(h_cfg),
    .phase(h_ph), .coord(h_coord), .last(h_last)
  );

  lrt_axis #(.MAX_ACT(MAX_H)) u_v_axis (
    .clk(clk), .rst_n(rst_n), .step(adv && h_last), .cfg(v_cfg),
    .phase(v_ph), .coord(v_coord), .last(v_last)
  );

  lrt_outreg #(.XW(XW), .YW(YW)) u_out (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .h_ph(h_ph), .v_ph(v_ph), .h_coord(h_coord), .v_coord(v_coord),
    .h_inv(hsync_inv), .v_inv(vsync_inv),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de(de),
    .pix_x(pix_x), .pix_y(pix_y), .frame_start(frame_start)
  );

endmodule

// File: rtl/lrt_checker.sv
`timescale 1ns/1ps
module lrt_checker #(
  parameter int MAX_W = 1366,
  parameter int MAX_H = 768
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     pix_ce,
  input logic                     hsync_inv,
  input logic                     hsync_o,
  input logic                     vsync_o,
  input logic                     de,
  input logic [$clog2(MAX_W)-1:0] pix_x,
  input logic [$clog2(MAX_H)-1:0] pix_y,
  input logic                     frame_start
);
  localparam int XW = $clog2(MAX_W);

  AST_HOLD_WITHOUT_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_ce |=> ($stable(hsync_o) && $stable(vsync_o) && $stable(de) && $stable(pix_x) && $stable(pix_y))); // R8

  AST_FS_AFTER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> $past(pix_ce)); // R9

  AST_FS_AT_REF_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (!de && (hsync_o == !$past(hsync_inv)))); // R9

  AST_X_CONSECUTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (de && $past(de) && $past(pix_ce)) |-> (pix_x == $past(pix_x) + XW'(1))); // R4

  AST_COORD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> ((int'(pix_x) < MAX_W) && (int'(pix_y) < MAX_H))); // R10

endmodule

bind lcd_raster_timing lrt_checker #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_lrt_checker (
  .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .hsync_inv(hsync_inv),
  .hsync_o(hsync_o), .vsync_o(vsync_o), .de(de),
  .pix_x(pix_x), .pix_y(pix_y), .frame_start(frame_start)
);

// File: tb/test_lcd_raster_timing.sv
`timescale 1ns/1ps
module test_lcd_raster_timing;
  localparam int MW = 20;
  localparam int MH = 12;
  localparam int XW = $clog2(MW);
  localparam int YW = $clog2(MH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_ce = 1'b0;
  logic hsync_inv = 1'b0, vsync_inv = 1'b0;
  logic [31:0] tm_sync = '0, tm_back = '0, tm_front = '0, tm_active = '0;
  logic hsync_o, vsync_o, de, frame_start;
  logic [XW-1:0] pix_x;
  logic [YW-1:0] pix_y;

  int n_chk = 0, n_fail = 0;
  int hs_, hb_, ha_, hf_, vs_, vb_, va_, vf_;
  int hp, vp;
  int e_hs, e_vs, e_de, e_x, e_y, e_fs;

  always #2.5 clk = ~clk;

  lcd_raster_timing #(.MAX_W(MW), .MAX_H(MH)) i_lcd_raster_timing (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce),
    .hsync_inv(hsync_inv), .vsync_inv(vsync_inv),
    .tm_sync(tm_sync), .tm_back(tm_back), .tm_front(tm_front), .tm_active(tm_active),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de(de),
    .pix_x(pix_x), .pix_y(pix_y), .frame_start(frame_start)
  );

  task automatic cmp(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (slot h=%0d v=%0d)", req, what, act, exp, hp, vp);
    end
  endtask

  task automatic compare_all();
    cmp("R2", "hsync_o", int'(hsync_o), e_hs);
    cmp("R3", "vsync_o", int'(vsync_o), e_vs);
    cmp("R4", "de", int'(de), e_de);
    cmp("R4", "pix_x", int'(pix_x), e_x);
    cmp("R4", "pix_y", int'(pix_y), e_y);
    cmp("R9", "frame_start", int'(frame_start), e_fs);
  endtask

  // R5: horizontal in 15:0, vertical in 31:16
  task automatic set_cfg(input int hs, input int hb, input int ha, input int hf,
                         input int vs, input int vb, input int va, input int vf);
    tm_sync   = {16'(vs), 16'(hs)};
    tm_back   = {16'(vb), 16'(hb)};
    tm_active = {16'(va), 16'(ha)};
    tm_front  = {16'(vf), 16'(hf)};
  endtask

  // R10: active clamped to the maxima
  task automatic load_cur();
    hs_ = int'(tm_sync[15:0]);   vs_ = int'(tm_sync[31:16]);
    hb_ = int'(tm_back[15:0]);   vb_ = int'(tm_back[31:16]);
    hf_ = int'(tm_front[15:0]);  vf_ = int'(tm_front[31:16]);
    ha_ = int'(tm_active[15:0]); va_ = int'(tm_active[31:16]);
    if (ha_ > MW) ha_ = MW;
    if (va_ > MH) va_ = MH;
  endtask

  function automatic int phase_of(input int p, input int s, input int b, input int a);
    if (p < 1) return 0;
    if (p < 1 + s) return 1;
    if (p < 1 + s + b) return 2;
    if (p < 1 + s + b + a) return 3;
    return 4;
  endfunction

  // R1: reset values, then the priming clock
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pix_ce = 1'b0;
    repeat (2) @(negedge clk);
    e_hs = 1; e_vs = 1; e_de = 0; e_x = 0; e_y = 0; e_fs = 0;
    cmp("R1", "hsync_o in reset", int'(hsync_o), 1);
    cmp("R1", "de in reset", int'(de), 0);
    rst_n = 1'b1;
    hp = 0; vp = 0;
    @(posedge clk);
    load_cur();
    @(negedge clk);
    cmp("R1", "hsync_o", int'(hsync_o), e_hs);
    cmp("R1", "vsync_o", int'(vsync_o), e_vs);
    cmp("R1", "de", int'(de), e_de);
    cmp("R1", "pix_x", int'(pix_x), e_x);
    cmp("R1", "pix_y", int'(pix_y), e_y);
    cmp("R1", "frame_start", int'(frame_start), e_fs);
  endtask

  // R12: an advancing edge presents the current slot, then the model moves on
  task automatic tick(input bit ce);
    int hph, vph;
    pix_ce = ce;
    @(posedge clk);
    if (ce) begin
      hph  = phase_of(hp, hs_, hb_, ha_);
      vph  = phase_of(vp, vs_, vb_, va_);
      e_hs = (hph == 1) ? int'(hsync_inv) : int'(!hsync_inv);
      e_vs = (vph == 1) ? int'(vsync_inv) : int'(!vsync_inv);
      e_de = (hph == 3 && vph == 3) ? 1 : 0;
      e_x  = e_de ? hp - (1 + hs_ + hb_) : 0;
      e_y  = e_de ? vp - (1 + vs_ + vb_) : 0;
      e_fs = (hp == 0 && vp == 0) ? 1 : 0;
      hp++;
      if (hp >= 1 + hs_ + hb_ + ha_ + hf_) begin
        hp = 0;
        vp++;
        if (vp >= 1 + vs_ + vb_ + va_ + vf_) begin
          vp = 0;
          load_cur();  // R11: new words only at the frame boundary
        end
      end
    end else begin
      e_fs = 0;  // R8: other outputs hold
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R2 R3 R4 R5 R12: basic raster, two frames plus
    set_cfg(2, 1, 4, 2, 1, 1, 3, 1);
    do_reset();
    for (int i = 0; i < 150; i++) tick(1'b1);

    // R8: sparse pixel enable
    for (int i = 0; i < 240; i++) tick((i % 3) == 0);

    // R7: both sync levels inverted
    hsync_inv = 1'b1; vsync_inv = 1'b1;
    for (int i = 0; i < 150; i++) tick(1'b1);
    hsync_inv = 1'b0; vsync_inv = 1'b0;

    // R6: zero-length sync, porches
    set_cfg(0, 0, 3, 0, 0, 2, 2, 0);
    do_reset();
    for (int i = 0; i < 50; i++) tick(1'b1);
    set_cfg(1, 0, 0, 1, 0, 0, 1, 0);
    do_reset();
    for (int i = 0; i < 30; i++) tick(1'b1);

    // R10: oversize active area
    set_cfg(1, 1, 30, 1, 1, 1, 15, 1);
    do_reset();
    for (int i = 0; i < 800; i++) tick(1'b1);

    // R11: timing rewritten mid-frame
    set_cfg(2, 1, 4, 2, 1, 1, 3, 1);
    do_reset();
    for (int i = 0; i < 30; i++) tick(1'b1);
    set_cfg(1, 2, 5, 1, 2, 0, 2, 2);
    for (int i = 0; i < 200; i++) tick(1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule